// File: doc/BRIEF.md
# Multi-Rail Undervoltage Permission Combiner

This block turns the qualified undervoltage status of four supply rails into drive permissions for one half-bridge. The rails are the logic supply, the driver bias supply, the bootstrap supply of the high side and the isolated secondary bias. Each rail arrives as one trip bit that an upstream qualification stage has already debounced. The block produces a permission for the high-side channel, a permission for the low-side channel and a combined permission. It also produces the two gate-enable outputs, which also take the controller enable and the two PWM inputs into account.

A scope input selects how trips reach the channels. In global scope a trip on any rail removes both permissions. In per-channel scope the logic and bias rails still feed both channels, while the bootstrap and secondary rails feed only the high side. A trip on a rail that can collapse on its own needs a hold-off before its channel comes back, which stops restart storms. Another configuration bit makes two channels that are both off come back on the same clock edge. A sticky four-bit register records which rail or rails caused the most recent trip. Writing ones to it clears the matching bits.

Top module: `uvlo_perm_combiner`

## Requirements
- R1: The trip-bit encoding is bit 0 logic supply, bit 1 driver bias, bit 2 bootstrap, bit 3 isolated secondary, with 1 meaning tripped. With `cfg_scope`=0 (global), any set bit sampled at a clock edge makes `perm_hs` and `perm_ls` low after that edge.
- R2: With `cfg_scope`=1 (per-channel), bits 0 and 1 remove both permissions, and bits 2 and 3 remove only `perm_hs`. A `perm_ls` that is already high stays high.
- R3: `perm_global` is high exactly when `perm_hs` and `perm_ls` are both high.
- R4: `gate_hs` = `perm_hs` AND `drive_en` AND `pwm_hi`, and `gate_ls` = `perm_ls` AND `drive_en` AND `pwm_lo`. No value of the enable or PWM inputs can raise a gate output on a channel that has a mapped rail tripped.
- R5: A channel whose outage involved only bits 0 and 1 gets its permission back after the first clock edge that samples all of its mapped rails clear.
- R6: A channel that had bit 2 or bit 3 mapped and tripped during its outage gets its permission back only after the (HOLD_CYC+1)-th consecutive clear edge. A new mapped trip during the count restarts the count.
- R7: With `cfg_sync`=1, two channels that are both without permission regain it on the same edge, which is the later of their individual recovery edges. A channel that still has permission is not affected.
- R8: On an edge where one or more trip bits rise, `trip_cause` is loaded with exactly the newly risen bits, which replace the earlier content. The register is otherwise sticky.
- R9: A one on bit i of `cause_clr` clears bit i of `trip_cause` at the next edge, unless a new trip is captured on that edge. Bits written with zero keep their value.
- R10: Reset is synchronous and active low. While it is held, both permissions, both gates and `trip_cause` are 0. The first edge after release with all rails clear raises both permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_trip | input | 4 | Qualified per-rail trip status (bit 0 logic, 1 bias, 2 bootstrap, 3 secondary) |
| cfg_scope | input | 1 | 0 = global scope, 1 = per-channel scope |
| cfg_sync | input | 1 | 1 = joint re-enable of channels that are both off |
| drive_en | input | 1 | Controller-level drive enable |
| pwm_hi | input | 1 | High-side PWM command |
| pwm_lo | input | 1 | Low-side PWM command |
| cause_clr | input | 4 | Write-one-to-clear pulse for `trip_cause` |
| perm_global | output | 1 | Both channels permitted |
| perm_hs | output | 1 | High-side permission |
| perm_ls | output | 1 | Low-side permission |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |
| trip_cause | output | 4 | Sticky record of the rails in the most recent trip |

## Verification
The assertions check these properties on every cycle:
- any trip in global scope removes both permissions on the next edge;
- the low side holds its permission through high-side-only trips;
- a hold-class trip keeps the channel off for at least one extra edge;
- two channels that are both off never come back one at a time under joint re-enable;
- the cause register captures new trips and honours clear pulses.

Some behaviour only the bench scenarios can show. The exact recovery edge, H+1 clear edges after a hold-class trip, is one. The later of the two recovery edges under joint re-enable is another. The count restarting after a re-trip in the middle of a hold-off is a third. The bench shows these by sweeping every trip pattern against both scopes and both re-enable settings and counting edges.

// File: rtl/uvlo_pkg.sv
// Shared definitions for the undervoltage permission combiner.
// Assumes the rail ordering below, which every mask parameter follows.
package uvlo_pkg;
    localparam int NUM_RAILS = 4;
    localparam int RAIL_LOGIC = 0;
    localparam int RAIL_BIAS  = 1;
    localparam int RAIL_BOOT  = 2;
    localparam int RAIL_SEC   = 3;
    localparam int NUM_CH     = 2;
    localparam int CH_HS      = 0;
    localparam int CH_LS      = 1;

    typedef enum logic {
        SCOPE_GLOBAL  = 1'b0,
        SCOPE_CHANNEL = 1'b1
    } scope_e;
endpackage

// File: rtl/uvlo_rail_router.sv
// Routes rail trip bits to each channel according to the selected scope.
// Produces, per channel, a blocked flag and a flag asking for a hold-off.
// Assumes trip bits are already qualified upstream. Purely combinational.
module uvlo_rail_router
    import uvlo_pkg::*;
#(
    parameter int          N_RAILS   = NUM_RAILS,
    parameter logic [N_RAILS-1:0] HS_MASK   = '1,
    parameter logic [N_RAILS-1:0] LS_MASK   = 4'b0011,
    parameter logic [N_RAILS-1:0] HOLD_MASK = 4'b1100
) (
    input  logic [N_RAILS-1:0] rail_trip,
    input  logic               scope,
    output logic [NUM_CH-1:0]  blocked,
    output logic [NUM_CH-1:0]  hold_req
);
    localparam logic [N_RAILS-1:0] ALL_RAILS = '1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [N_RAILS-1:0] CH_MASK = (ch == CH_HS) ? HS_MASK : LS_MASK;
        logic [N_RAILS-1:0] eff_mask;
        logic [N_RAILS-1:0] hit;

        // Pick the rail set feeding this channel under the current scope.
        always_comb begin
            eff_mask = (scope == SCOPE_GLOBAL) ? ALL_RAILS : CH_MASK;
            hit      = rail_trip & eff_mask;
        end

        assign blocked[ch]  = |hit;
        assign hold_req[ch] = |(hit & HOLD_MASK);
    end
endmodule

// File: rtl/uvlo_chan_recovery.sv
// Per-channel recovery tracker. A channel is ready when it is not blocked
// and no hold-off is outstanding. A hold-off is armed by any hold-class
// trip while blocked. It then needs HOLD_CYC clear edges before ready rises,
// and it restarts if the channel is blocked again.
module uvlo_chan_recovery #(
    parameter int HOLD_CYC = 8,
    localparam int CNT_W = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blocked,
    input  logic hold_req,
    output logic ready
);
    logic             need_hold;
    logic [CNT_W-1:0] hold_cnt;

    assign ready = !blocked && !need_hold;

    // Arm, count and release the recovery hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_hold <= 1'b0;
            hold_cnt  <= '0;
        end else if (blocked) begin
            hold_cnt <= '0;
            if (hold_req) need_hold <= 1'b1;
        end else if (need_hold) begin
            if (hold_cnt == CNT_W'(HOLD_CYC - 1)) begin
                need_hold <= 1'b0;
                hold_cnt  <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // R6: a hold-class trip keeps the channel not ready on the next cycle.
    assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && hold_req) |=> !ready);
endmodule

// File: rtl/uvlo_sync_gate.sv
// Registers the two channel permissions. When joint re-enable is selected,
// a channel that is off may rise only when the other channel is also
// ready, so two channels that are both off return on the same edge.
module uvlo_sync_gate
    import uvlo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [NUM_CH-1:0] ready,
    output logic [NUM_CH-1:0] perm
);
    logic [NUM_CH-1:0] perm_d;

    // Next permission per channel, with the joint-recovery condition.
    always_comb begin
        perm_d[CH_HS] = ready[CH_HS] && (!sync_en || perm[CH_HS] || ready[CH_LS]);
        perm_d[CH_LS] = ready[CH_LS] && (!sync_en || perm[CH_LS] || ready[CH_HS]);
    end

    // Hold the registered permissions.
    always_ff @(posedge clk) begin
        if (!rst_n) perm <= '0;
        else        perm <= perm_d;
    end

    // R7: with joint re-enable, two off channels never rise one at a time.
    assert_joint_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && perm == 2'b00) |=> (perm == 2'b00 || perm == 2'b11));
endmodule

// File: rtl/uvlo_cause_reg.sv
// Sticky record of the rails that took part in the most recent trip.
// Newly rising trip bits replace the content. A clear pulse removes the
// bits it marks, and a capture on the same edge wins over the clear.
module uvlo_cause_reg #(
    parameter int N_RAILS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] rail_trip,
    input  logic [N_RAILS-1:0] clr,
    output logic [N_RAILS-1:0] cause
);
    logic [N_RAILS-1:0] trip_q;
    logic [N_RAILS-1:0] new_trip;

    assign new_trip = rail_trip & ~trip_q;

    // Track the previous trip state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trip_q <= '0;
        else        trip_q <= rail_trip;
    end

    // Capture a new cause or apply the write-one-to-clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          cause <= '0;
        else if (|new_trip)  cause <= new_trip;
        else                 cause <= cause & ~clr;
    end

    // R8: a new trip is captured exactly.
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|new_trip) |=> (cause == $past(new_trip)));
    // R9: cleared bits are zero unless a capture took place.
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (new_trip == '0) |=> ((cause & $past(clr)) == '0));
endmodule

// File: rtl/uvlo_perm_combiner.sv
// Top of the multi-rail undervoltage permission combiner for one
// half-bridge. It routes the rail trips by scope, tracks recovery and
// hold-off per channel, applies joint re-enable, gates the PWM commands
// and records the trip cause. Trip inputs are assumed to be synchronous
// and qualified. Reset is synchronous, active low.
module uvlo_perm_combiner
    import uvlo_pkg::*;
#(
    parameter int HOLD_CYC = 8,
    parameter logic [NUM_RAILS-1:0] HS_MASK   = 4'b1111,
    parameter logic [NUM_RAILS-1:0] LS_MASK   = 4'b0011,
    parameter logic [NUM_RAILS-1:0] HOLD_MASK = 4'b1100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_trip,
    input  logic                 cfg_scope,
    input  logic                 cfg_sync,
    input  logic                 drive_en,
    input  logic                 pwm_hi,
    input  logic                 pwm_lo,
    input  logic [NUM_RAILS-1:0] cause_clr,
    output logic                 perm_global,
    output logic                 perm_hs,
    output logic                 perm_ls,
    output logic                 gate_hs,
    output logic                 gate_ls,
    output logic [NUM_RAILS-1:0] trip_cause
);
    logic [NUM_CH-1:0] blocked;
    logic [NUM_CH-1:0] hold_req;
    logic [NUM_CH-1:0] ready;
    logic [NUM_CH-1:0] perm;

    uvlo_rail_router #(
        .N_RAILS(NUM_RAILS), .HS_MASK(HS_MASK),
        .LS_MASK(LS_MASK), .HOLD_MASK(HOLD_MASK)
    ) u_router (
        .rail_trip(rail_trip), .scope(cfg_scope),
        .blocked(blocked), .hold_req(hold_req)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rec
        uvlo_chan_recovery #(.HOLD_CYC(HOLD_CYC)) u_rec (
            .clk(clk), .rst_n(rst_n),
            .blocked(blocked[ch]), .hold_req(hold_req[ch]),
            .ready(ready[ch])
        );
    end

    uvlo_sync_gate u_sync (
        .clk(clk), .rst_n(rst_n), .sync_en(cfg_sync),
        .ready(ready), .perm(perm)
    );

    uvlo_cause_reg #(.N_RAILS(NUM_RAILS)) u_cause (
        .clk(clk), .rst_n(rst_n), .rail_trip(rail_trip),
        .clr(cause_clr), .cause(trip_cause)
    );

    // Drive the permission and gate outputs; undervoltage dominates.
    always_comb begin
        perm_hs     = perm[CH_HS];
        perm_ls     = perm[CH_LS];
        perm_global = perm_hs && perm_ls;
        gate_hs     = perm_hs && drive_en && pwm_hi;
        gate_ls     = perm_ls && drive_en && pwm_lo;
    end

    // R1: in global scope any trip removes both permissions.
    assert_global_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_scope == SCOPE_GLOBAL && |rail_trip) |=> (!perm_hs && !perm_ls));
    // R2: in per-channel scope the low side survives high-side-only trips.
    assert_ls_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_scope == SCOPE_CHANNEL && (rail_trip & LS_MASK) == '0 && perm_ls)
        |=> perm_ls);
    // R4: a mapped trip leaves no gate output high on the next cycle.
    assert_gate_dominance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rail_trip & LS_MASK)) |=> (!gate_hs && !gate_ls));
endmodule

// File: tb/sim_uvlo_perm_combiner.sv
module sim_uvlo_perm_combiner;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rail_trip = '0;
    logic       cfg_scope = 1'b0, cfg_sync = 1'b0;
    logic       drive_en = 1'b0, pwm_hi = 1'b0, pwm_lo = 1'b0;
    logic [3:0] cause_clr = '0;
    logic       perm_global, perm_hs, perm_ls, gate_hs, gate_ls;
    logic [3:0] trip_cause;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uvlo_perm_combiner #(.HOLD_CYC(H)) u0 (
        .clk(clk), .rst_n(rst_n), .rail_trip(rail_trip),
        .cfg_scope(cfg_scope), .cfg_sync(cfg_sync), .drive_en(drive_en),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cause_clr(cause_clr),
        .perm_global(perm_global), .perm_hs(perm_hs), .perm_ls(perm_ls),
        .gate_hs(gate_hs), .gate_ls(gate_ls), .trip_cause(trip_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ch_mask(input int ch, input logic scope);
        if (!scope) return 4'b1111;
        return (ch == 0) ? 4'b1111 : 4'b0011;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        repeat (3) step();
        chk("R10 perm_hs reset", perm_hs, 0);
        chk("R10 perm_ls reset", perm_ls, 0);
        chk("R10 cause reset", trip_cause, 0);
        rst_n = 1'b1;
        step();
        chk("R10 perm_global first edge", perm_global, 1);

        // Sweep every pattern against both scopes and both sync settings.
        for (int sc = 0; sc < 2; sc++) begin
            for (int sy = 0; sy < 2; sy++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [3:0] pat;
                    bit off_h, off_l, hold_h, hold_l;
                    int t_h, t_l, e_h, e_l, r_h, r_l;
                    pat = 4'(p);
                    cfg_scope = sc[0];
                    cfg_sync  = sy[0];
                    off_h  = |(pat & ch_mask(0, sc[0]));
                    off_l  = |(pat & ch_mask(1, sc[0]));
                    hold_h = |(pat & ch_mask(0, sc[0]) & 4'b1100);
                    hold_l = |(pat & ch_mask(1, sc[0]) & 4'b1100);
                    rail_trip = pat;
                    drive_en = 1'b1; pwm_hi = 1'b1; pwm_lo = 1'b1;
                    step();
                    chk(sc ? "R2 perm_hs" : "R1 perm_hs", perm_hs, !off_h);
                    chk(sc ? "R2 perm_ls" : "R1 perm_ls", perm_ls, !off_l);
                    chk("R3 perm_global", perm_global, !off_h && !off_l);
                    chk("R4 gate_hs", gate_hs, !off_h);
                    chk("R4 gate_ls", gate_ls, !off_l);
                    chk("R8 cause capture", trip_cause, pat);
                    cause_clr = pat;
                    step();
                    cause_clr = '0;
                    chk("R9 cause cleared", trip_cause, 0);
                    // Release the rails and time each channel's return.
                    rail_trip = '0;
                    t_h = hold_h ? H + 1 : 1;
                    t_l = hold_l ? H + 1 : 1;
                    e_h = !off_h ? 1 : ((sy && off_l) ? ((t_h > t_l) ? t_h : t_l) : t_h);
                    e_l = !off_l ? 1 : ((sy && off_h) ? ((t_h > t_l) ? t_h : t_l) : t_l);
                    r_h = 0; r_l = 0;
                    for (int i = 1; i <= H + 3; i++) begin
                        step();
                        if (perm_hs && r_h == 0) r_h = i;
                        if (perm_ls && r_l == 0) r_l = i;
                    end
                    if (sy) begin
                        chk("R7 hs return edge", r_h, e_h);
                        chk("R7 ls return edge", r_l, e_l);
                    end else begin
                        chk(hold_h ? "R6 hs return edge" : "R5 hs return edge", r_h, e_h);
                        chk(hold_l ? "R6 ls return edge" : "R5 ls return edge", r_l, e_l);
                    end
                end
            end
        end

        // R4: enable and PWM inputs mask the gates when permitted.
        cfg_scope = 1'b1; cfg_sync = 1'b0;
        drive_en = 1'b0;
        #1 chk("R4 gate_hs drive_en low", gate_hs, 0);
        drive_en = 1'b1; pwm_hi = 1'b0;
        #1 chk("R4 gate_hs pwm low", gate_hs, 0);
        chk("R4 gate_ls pwm high", gate_ls, 1);

        // R6: a re-trip during hold-off restarts the count.
        rail_trip = 4'b0100; step();
        rail_trip = 4'b0000; step(); step();
        rail_trip = 4'b0100; step();
        rail_trip = 4'b0000;
        begin
            int r = 0;
            for (int i = 1; i <= H + 3; i++) begin
                step();
                if (perm_hs && r == 0) r = i;
            end
            chk("R6 restart after re-trip", r, H + 1);
        end

        // R8: a newer trip replaces the earlier cause.
        cause_clr = 4'hF; step(); cause_clr = '0;
        rail_trip = 4'b0001; step();
        rail_trip = 4'b1001; step();
        chk("R8 newest replaces", trip_cause, 4'b1000);
        // R9: partial clear keeps the unmarked bits.
        rail_trip = 4'b0000; step();
        rail_trip = 4'b0101; step();
        cause_clr = 4'b0001; step(); cause_clr = '0;
        chk("R9 partial clear", trip_cause, 4'b0100);
        // R9: a capture on the clear edge wins.
        rail_trip = 4'b0111; cause_clr = 4'b0010; step(); cause_clr = '0;
        chk("R9 capture beats clear", trip_cause, 4'b0010);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule